// File: doc/BRIEF.md
# Microcontroller interrupt control unit

This block is the interrupt logic that sits beside the datapath of a small 8-bit microcontroller core. It collects three request sources: a rising edge on an external interrupt pin, a one-clock overflow pulse from a timer, and a one-clock pulse from a pin-change detector that watches a group of four port pins. Each source owns a sticky flag and an individual enable bit. A global enable sits beside them, and all of these live in one 8-bit control register that the CPU reads and writes. The timer, the pin-change detector, the stack and the program counter live elsewhere and meet this block only at its ports.

The CPU marks the end of every instruction cycle with the `cyc_end` strobe. At such a boundary the unit arms a request when the global enable is set and some flag meets its enable. At the next boundary it acts on that request. If the global enable is still set, it issues a one-clock `take_o` pulse. That pulse tells the CPU to push the return address and load the vector on `vec_o`, and the same edge clears the global enable. If an instruction cleared the global enable in the meantime, the unit issues `nop_o` instead, and the flag stays pending. A return-from-interrupt pulse sets the global enable again. A `wake_o` output tells a sleeping core that an enabled flag is set, whatever the state of the global enable.

Top module: `irq_unit`

## Requirements
- R1: After reset the control register reads 0x00, and `take_o`, `nop_o`, `wake_o` and `vec_o` are all zero.
- R2: Control register layout: bit 7 global enable; bits 6, 5, 4 enable the timer, external-pin and pin-change sources; bit 3 is spare and always reads 0; bits 2, 1, 0 are the timer, external-pin and pin-change flags. A write is visible on `ctrl_rd` after the clock edge that takes it.
- R3: A source event sets its flag whatever its enable bit and the global enable hold. Flags are cleared only by a software write of 0, and an event on the same clock as such a write leaves the flag set.
- R4: A rising edge on `ext_pin` sets flag bit 1 exactly SYNC_STAGES clock edges after the edge that first samples the high level. A level held high does not set the flag again.
- R5: When the global enable is set and some flag meets its enable at a `cyc_end` edge, `take_o` pulses for one clock at the following `cyc_end` edge. The same edge clears bit 7, and `vec_o` shows VEC_ADDR for that one clock (zero otherwise).
- R6: No `take_o` is issued while the global enable is clear, or while every set flag has its enable clear.
- R7: If a write clears the global enable after a request was armed, the next `cyc_end` edge gives a one-clock `nop_o` pulse instead of `take_o`, and the flag stays set.
- R8: A `retfie` pulse sets bit 7. If an enabled flag is still set, `take_o` follows at the second `cyc_end` edge after that.
- R9: `wake_o` equals, one clock later, the OR of each flag ANDed with its enable, independent of bit 7.
- R10: At a `cyc_end` edge where `take_o` is issued, clearing bit 7 wins over a simultaneous `retfie` or software write that sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | Instruction-cycle boundary strobe from the CPU |
| ext_pin | input | 1 | Raw external interrupt pin (rising edge, synchronised inside) |
| tmr_ovf | input | 1 | One-clock timer overflow pulse |
| pin_chg | input | 1 | One-clock pulse from the port pin-change detector |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| retfie | input | 1 | Return-from-interrupt executed (one clock) |
| ctrl_rd | output | 8 | Control register contents |
| take_o | output | 1 | Take the interrupt: push the return address and load the vector |
| nop_o | output | 1 | Suppressed request: the CPU executes a NOP this cycle |
| vec_o | output | PC_W | Interrupt vector, valid while take_o is high |
| wake_o | output | 1 | Wake-up request for sleep mode |

## Verification
The bench builds the unit with SYNC_STAGES = 3, PC_W = 13 and VEC_ADDR = 4, and strobes `cyc_end` every fourth clock. The deeper synchroniser puts the pin-to-flag delay at a point where it can lag or lead a cycle boundary. The four-clock cycle lets the bench place writes and return pulses between an arming edge and a firing edge, and also exactly on a firing edge. With these settings the suppressed-request NOP, the take-versus-set priority and the re-entry after return can each be steered by a directed sequence. A long random run then mixes all sources, writes and returns against the cycle-accurate model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // number of request sources held in the control register
  localparam int N_SRC     = 3;
  localparam int REG_W     = 8;
  // field placement inside the control register
  localparam int GIE_BIT   = 7;
  localparam int EN_LSB    = 4;
  localparam int SPARE_BIT = 3;
  localparam int FLAG_LSB  = 0;

  // source index: flag at FLAG_LSB+idx, enable at EN_LSB+idx
  typedef enum int {
    SRC_CHG = 0,
    SRC_EXT = 1,
    SRC_TMR = 2
  } irq_src_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q[0] <= pin;
      for (int k = 1; k < STAGES; k++) begin
        sh_q[k] <= sh_q[k-1];
      end
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [N_SRC-1:0] ev,
  input  logic             hw_take,
  input  logic             retfie,
  output logic             gie,
  output logic [N_SRC-1:0] en,
  output logic [N_SRC-1:0] flag
);
  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_src
      // an event always wins over a clearing write
      always_ff @(posedge clk) begin
        if (rst) begin
          flag[i] <= 1'b0;
        end else begin
          flag[i] <= (wr_en ? wr_data[FLAG_LSB+i] : flag[i]) | ev[i];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          en[i] <= 1'b0;
        end else if (wr_en) begin
          en[i] <= wr_data[EN_LSB+i];
        end
      end
    end
  endgenerate

  // priority: hardware take clear, then return, then software write
  always_ff @(posedge clk) begin
    if (rst) begin
      gie <= 1'b0;
    end else if (hw_take) begin
      gie <= 1'b0;
    end else if (retfie) begin
      gie <= 1'b1;
    end else if (wr_en) begin
      gie <= wr_data[GIE_BIT];
    end
  end
endmodule

// File: rtl/irq_take_seq.sv
module irq_take_seq (
  input  logic clk,
  input  logic rst,
  input  logic cyc_end,
  input  logic gie,
  input  logic pend,
  output logic take_now,
  output logic take_q,
  output logic nop_q
);
  logic armed_q;
  logic fire;

  assign fire     = cyc_end & armed_q;
  assign take_now = fire & gie;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      take_q  <= 1'b0;
      nop_q   <= 1'b0;
    end else begin
      if (cyc_end) begin
        armed_q <= gie & pend & ~take_now;
      end
      take_q <= take_now;
      nop_q  <= fire & ~gie;
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PC_W        = 13,
  parameter int VEC_ADDR    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_end,
  input  logic            ext_pin,
  input  logic            tmr_ovf,
  input  logic            pin_chg,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            retfie,
  output logic [7:0]      ctrl_rd,
  output logic            take_o,
  output logic            nop_o,
  output logic [PC_W-1:0] vec_o,
  output logic            wake_o
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  logic             ext_rise;
  logic [N_SRC-1:0] ev;
  logic             gie;
  logic [N_SRC-1:0] en;
  logic [N_SRC-1:0] flag;
  logic             pend;
  logic             take_now;
  logic             wake_q;
  logic [PC_W-1:0]  vec_q;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .rise (ext_rise)
  );

  always_comb begin
    ev          = '0;
    ev[SRC_CHG] = pin_chg;
    ev[SRC_EXT] = ext_rise;
    ev[SRC_TMR] = tmr_ovf;
  end

  irq_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ev      (ev),
    .hw_take (take_now),
    .retfie  (retfie),
    .gie     (gie),
    .en      (en),
    .flag    (flag)
  );

  assign pend = |(en & flag);

  irq_take_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .cyc_end  (cyc_end),
    .gie      (gie),
    .pend     (pend),
    .take_now (take_now),
    .take_q   (take_o),
    .nop_q    (nop_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      wake_q <= pend;
      vec_q  <= take_now ? VEC : '0;
    end
  end

  assign wake_o  = wake_q;
  assign vec_o   = vec_q;
  assign ctrl_rd = {gie, en, 1'b0, flag};
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc_end,
  input logic       wr_en,
  input logic       retfie,
  input logic [7:0] ctrl_rd,
  input logic       take_o,
  input logic       nop_o,
  input logic       wake_o
);
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd[3] == 1'b0);

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((ctrl_rd[2:0] & $past(ctrl_rd[2:0])) == $past(ctrl_rd[2:0])));

  a_r5_take_clears_gie: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ctrl_rd[7]);

  a_r5_take_one_clk: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);

  a_r6_take_needs_gie: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(ctrl_rd[7]));

  a_r7_nop_not_take: assert property (@(posedge clk) disable iff (rst)
    !(take_o && nop_o));

  a_r7_nop_gie_clear: assert property (@(posedge clk) disable iff (rst)
    nop_o |-> !$past(ctrl_rd[7]));

  a_r8_retfie_sets: assert property (@(posedge clk) disable iff (rst)
    (retfie && !cyc_end) |=> ctrl_rd[7]);

  a_r9_wake_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> ($past(ctrl_rd[6:4] & ctrl_rd[2:0]) != 3'b000));
endmodule

bind irq_unit irq_unit_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cyc_end (cyc_end),
  .wr_en   (wr_en),
  .retfie  (retfie),
  .ctrl_rd (ctrl_rd),
  .take_o  (take_o),
  .nop_o   (nop_o),
  .wake_o  (wake_o)
);

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
  localparam int SYNC = 3;
  localparam int PCW  = 13;
  localparam int VEC  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cyc_end;
  logic           ext_pin = 1'b0;
  logic           tmr_ovf = 1'b0;
  logic           pin_chg = 1'b0;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_data = 8'h00;
  logic           retfie = 1'b0;
  logic [7:0]     ctrl_rd;
  logic           take_o;
  logic           nop_o;
  logic [PCW-1:0] vec_o;
  logic           wake_o;

  int n_chk = 0;
  int n_fail = 0;
  int ph = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) ph <= ph + 1;
  assign cyc_end = ((ph % 4) == 3);

  irq_unit #(.SYNC_STAGES(SYNC), .PC_W(PCW), .VEC_ADDR(VEC)) u_irq_unit (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .ext_pin(ext_pin),
    .tmr_ovf(tmr_ovf), .pin_chg(pin_chg), .wr_en(wr_en), .wr_data(wr_data),
    .retfie(retfie), .ctrl_rd(ctrl_rd), .take_o(take_o), .nop_o(nop_o),
    .vec_o(vec_o), .wake_o(wake_o)
  );

  // reference model state
  bit       m_gie, m_armed, m_take, m_nop, m_wake, m_last;
  bit [2:0] m_en, m_f;
  bit       m_hist[$];

  always @(posedge clk) begin
    bit [2:0] evs;
    bit pend, fire, tk, rise;
    if (rst) begin
      m_gie = 0; m_armed = 0; m_take = 0; m_nop = 0; m_wake = 0; m_last = 0;
      m_en = 0; m_f = 0;
      m_hist.delete();
      for (int k = 0; k < SYNC; k++) m_hist.push_back(1'b0);
    end else begin
      rise = m_hist[SYNC-1] && !m_last;
      evs  = {tmr_ovf, rise, pin_chg};
      pend = |(m_en & m_f);
      fire = cyc_end && m_armed;
      tk   = fire && m_gie;
      m_wake = pend;
      m_take = tk;
      m_nop  = fire && !m_gie;
      if (cyc_end) m_armed = m_gie && pend && !tk;
      if (tk) m_gie = 0;
      else if (retfie) m_gie = 1;
      else if (wr_en) m_gie = wr_data[7];
      m_f = (wr_en ? wr_data[2:0] : m_f) | evs;
      if (wr_en) m_en = wr_data[6:4];
      m_last = m_hist[SYNC-1];
      m_hist.push_front(ext_pin);
      void'(m_hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(ctrl_rd == {m_gie, m_en, 1'b0, m_f}, "R2/R3/R4/R8/R10 ctrl_rd",
          int'(ctrl_rd), int'({m_gie, m_en, 1'b0, m_f}));
      chk(take_o == m_take, "R5/R6 take_o", int'(take_o), int'(m_take));
      chk(nop_o == m_nop, "R7 nop_o", int'(nop_o), int'(m_nop));
      chk(vec_o == (m_take ? PCW'(VEC) : '0), "R5 vec_o", int'(vec_o),
          m_take ? VEC : 0);
      chk(wake_o == m_wake, "R9 wake_o", int'(wake_o), int'(m_wake));
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic pulse_ret();
    retfie = 1'b1; @(negedge clk); retfie = 1'b0;
  endtask

  task automatic after_ce();
    while (!cyc_end) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic count_takes(input int n, output int takes, output int nops);
    takes = 0; nops = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (take_o) takes++;
      if (nop_o) nops++;
    end
  endtask

  initial begin
    int t, nn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctrl_rd == 8'h00, "R1 reset ctrl", int'(ctrl_rd), 0);
    chk(!take_o && !nop_o && !wake_o && vec_o == '0, "R1 reset outs",
        int'({take_o, nop_o, wake_o}), 0);

    // R2: layout and spare bit
    wr(8'h7F);
    chk(ctrl_rd == 8'h77, "R2 spare reads 0", int'(ctrl_rd), 'h77);
    wr(8'h00);

    // R3: flags latch with everything masked; R4 pin latency
    pulse_tmr();
    pin_chg = 1'b1; @(negedge clk); pin_chg = 1'b0;
    chk(ctrl_rd == 8'h05, "R3 flags masked", int'(ctrl_rd), 'h05);
    ext_pin = 1'b1;
    repeat (SYNC) @(negedge clk);
    chk(ctrl_rd[1] == 1'b0, "R4 ext not yet", int'(ctrl_rd[1]), 0);
    @(negedge clk);
    chk(ctrl_rd[1] == 1'b1, "R4 ext set", int'(ctrl_rd[1]), 1);
    wr(8'h00);
    repeat (6) @(negedge clk);
    chk(ctrl_rd[1] == 1'b0, "R4 held level no reset", int'(ctrl_rd[1]), 0);
    ext_pin = 1'b0;
    // R3: event beats clearing write
    wr_en = 1'b1; wr_data = 8'h00; tmr_ovf = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tmr_ovf = 1'b0;
    chk(ctrl_rd[2] == 1'b1, "R3 event beats clear", int'(ctrl_rd[2]), 1);

    // R9 and R6: enabled flag without global enable
    wr(8'h44);
    @(negedge clk);
    chk(wake_o == 1'b1, "R9 wake without gie", int'(wake_o), 1);
    count_takes(12, t, nn);
    chk(t == 0, "R6 no take gie clear", t, 0);
    // R6: global enable, mismatched enable
    wr(8'h94);
    count_takes(12, t, nn);
    chk(t == 0, "R6 no take masked", t, 0);

    // R5: take
    wr(8'hC4);
    count_takes(12, t, nn);
    chk(t == 1, "R5 one take", t, 1);
    chk(ctrl_rd[7] == 1'b0, "R5 gie cleared", int'(ctrl_rd[7]), 0);

    // R8: return with flag still set re-enters
    pulse_ret();
    count_takes(12, t, nn);
    chk(t == 1, "R8 re-entry", t, 1);
    wr(8'h40);
    pulse_ret();
    count_takes(12, t, nn);
    chk(t == 0, "R8 no pending no take", t, 0);

    // R7: clear gie after arming
    wr(8'h44);
    after_ce();
    wr(8'hC4);
    after_ce();
    wr(8'h44);
    while (!cyc_end) @(negedge clk);
    @(negedge clk);
    chk(nop_o == 1'b1 && take_o == 1'b0, "R7 nop instead of take",
        int'({nop_o, take_o}), 2);
    chk(ctrl_rd == 8'h44, "R7 flag still pending", int'(ctrl_rd), 'h44);
    pulse_ret();
    count_takes(12, t, nn);
    chk(t == 1, "R7 pending served after return", t, 1);

    // R10: take wins over simultaneous set
    wr(8'hC4);
    after_ce();
    while (!cyc_end) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hC4; retfie = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; retfie = 1'b0;
    chk(take_o == 1'b1 && ctrl_rd[7] == 1'b0, "R10 take wins",
        int'({take_o, ctrl_rd[7]}), 2);
    wr(8'h00);

    // mixed random traffic, checked by the model every clock
    for (int k = 0; k < 3000; k++) begin
      tmr_ovf = ($urandom % 16) == 0;
      pin_chg = ($urandom % 16) == 0;
      if (($urandom % 8) == 0) ext_pin = ~ext_pin;
      wr_en   = ($urandom % 20) == 0;
      wr_data = 8'($urandom);
      retfie  = ($urandom % 30) == 0;
      @(negedge clk);
    end
    tmr_ovf = 0; pin_chg = 0; wr_en = 0; retfie = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule